// File: doc/BRIEF.md
# Encoded Status Bus Command Decoder

This block sits next to a processor whose bus runs in its encoded-status mode. The processor does not drive read or write strobes itself. It puts a three-bit status code on dedicated lines instead. The decoder samples those lines and the READY input on every rising clock edge and rebuilds the bus control signals from them. Those signals are five command strobes, an address-latch pulse, a data-buffer enable and a data-buffer direction.

A bus cycle begins when the status leaves the passive code (all ones) while the decoder is idle and armed. The next clock carries an address-latch pulse. From the clock after that, the strobe that belongs to the latched code is held. It stays until the decoder samples the passive code and READY high in the same clock. Holding READY low stretches the strobe for as long as it stays low. After a cycle ends, the status must be seen passive for at least one clock before a new cycle can start. All outputs are active high.

Top module: `stsdec_top`

## Requirements
- R1: While `rst` is high, and in the first clock after it falls, every output is low. The decoder comes out of reset unarmed, so a non-passive code sampled at the first edge after reset starts no cycle.
- R2: The decoder arms when it samples `stat`=3'b111 while idle. If an armed, idle decoder samples a code other than 3'b111, a new cycle starts and `ale` is high for exactly the one clock that follows that edge. Halt cycles are the exception (see R4).
- R3: The latched code selects the strobe: 3'b000 drives `int_ack`, 3'b001 drives `rd_io`, 3'b010 drives `wr_io`, 3'b100 and 3'b101 both drive `rd_mem`, and 3'b110 drives `wr_mem`.
- R4: The halt code 3'b011 runs through the cycle sequence but raises no strobe. It also leaves `ale`, `den` and `dir_out` low.
- R5: The strobe of a cycle rises in the clock right after the `ale` clock. It falls in the clock after the first edge at which `stat`=3'b111 and `ready`=1 are sampled together.
- R6: While `ready` is sampled low, an active strobe stays high, even if the status already reads passive.
- R7: `den` is high in exactly the clocks in which a command strobe is high.
- R8: `dir_out` is high from the `ale` clock to the end of the strobe window for codes 3'b010 and 3'b110. It is low in every other clock.
- R9: Once a cycle has ended, a non-passive code in the very next sample starts no cycle. A change of status inside a running cycle does not restart it.
- R10: At most one of the five command strobes is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stat | input | 3 | Encoded status from the processor |
| ready | input | 1 | Transfer-complete acknowledge, high ends the cycle |
| ale | output | 1 | Address latch pulse |
| int_ack | output | 1 | Interrupt acknowledge strobe |
| rd_io | output | 1 | I/O read strobe |
| wr_io | output | 1 | I/O write strobe |
| rd_mem | output | 1 | Memory read strobe, also used for code fetch |
| wr_mem | output | 1 | Memory write strobe |
| den | output | 1 | Data buffer enable |
| dir_out | output | 1 | Data buffer direction, high drives toward the bus |

## Verification
The bench targets four corner cases:
- A non-passive code right after reset. A decoder that comes out of reset armed would put out a false address pulse.
- A non-passive code immediately after a cycle ends. A decoder without the one-clock rearm would start a phantom cycle there.
- Passive status combined with READY low. A decoder that ends the cycle on status alone would cut a stretched strobe short.
- The halt code and the code-fetch code. Simple decoders commonly give halt a strobe or a latch pulse, or fail to map code fetch onto the memory read strobe.

// File: rtl/stsdec_pkg.sv
package stsdec_pkg;

    localparam int STAT_W = 3;

    typedef enum logic [STAT_W-1:0] {
        ST_INTA  = 3'b000,
        ST_IORD  = 3'b001,
        ST_IOWR  = 3'b010,
        ST_HALT  = 3'b011,
        ST_FETCH = 3'b100,
        ST_MRD   = 3'b101,
        ST_MWR   = 3'b110,
        ST_IDLE  = 3'b111
    } stat_code_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LATCH = 2'd1,
        PH_CMD   = 2'd2
    } phase_e;

    typedef struct packed {
        logic int_ack;
        logic rd_io;
        logic wr_io;
        logic rd_mem;
        logic wr_mem;
    } strobe_t;

    localparam int STROBE_W = $bits(strobe_t);

    function automatic strobe_t code_to_strobe(stat_code_e c);
        strobe_t s;
        s = '0;
        case (c)
            ST_INTA:          s.int_ack = 1'b1;
            ST_IORD:          s.rd_io   = 1'b1;
            ST_IOWR:          s.wr_io   = 1'b1;
            ST_FETCH, ST_MRD: s.rd_mem  = 1'b1;
            ST_MWR:           s.wr_mem  = 1'b1;
            default:          s = '0;
        endcase
        return s;
    endfunction

    function automatic logic code_is_write(stat_code_e c);
        return (c == ST_IOWR) || (c == ST_MWR);
    endfunction

endpackage

// File: rtl/stsdec_tracker.sv
module stsdec_tracker
    import stsdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] stat,
    input  logic              ready,
    output phase_e            phase,
    output stat_code_e        kind
);

    logic       armed;
    stat_code_e code_in;

    assign code_in = stat_code_e'(stat);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            kind  <= ST_IDLE;
            armed <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (code_in == ST_IDLE) begin
                        armed <= 1'b1;
                    end else if (armed) begin
                        phase <= PH_LATCH;
                        kind  <= code_in;
                        armed <= 1'b0;
                    end
                end
                PH_LATCH: phase <= PH_CMD;
                PH_CMD: begin
                    if (code_in == ST_IDLE && ready) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_LATCH_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        phase == PH_LATCH |=> phase == PH_CMD); // R2

    AST_REARM_GAP: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CMD && code_in == ST_IDLE && ready) |=> phase == PH_IDLE ##1 phase == PH_IDLE); // R9

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CMD && !ready) |=> phase == PH_CMD); // R6

endmodule

// File: rtl/stsdec_cmdgen.sv
module stsdec_cmdgen
    import stsdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  phase_e     phase,
    input  stat_code_e kind,
    output strobe_t    strobes,
    output logic       ale,
    output logic       den,
    output logic       dir_out
);

    strobe_t decoded;
    logic    in_cycle;

    assign decoded  = code_to_strobe(kind);
    assign in_cycle = (phase != PH_IDLE) && (kind != ST_HALT);

    always_comb begin
        strobes = '0;
        if (phase == PH_CMD) strobes = decoded;
    end

    assign ale     = (phase == PH_LATCH) && (kind != ST_HALT);
    assign den     = (phase == PH_CMD) && (decoded != '0);
    assign dir_out = in_cycle && code_is_write(kind);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $countones(strobes) <= 1); // R10

    AST_ALE_PULSE: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale); // R2

    AST_NO_DIR_IDLE: assert property (@(posedge clk) disable iff (rst)
        phase == PH_IDLE |-> !dir_out); // R8

endmodule

// File: rtl/stsdec_top.sv
module stsdec_top
    import stsdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] stat,
    input  logic              ready,
    output logic              ale,
    output logic              int_ack,
    output logic              rd_io,
    output logic              wr_io,
    output logic              rd_mem,
    output logic              wr_mem,
    output logic              den,
    output logic              dir_out
);

    phase_e     phase;
    stat_code_e kind;
    strobe_t    strobes;
    logic       any_cmd;

    stsdec_tracker u_tracker (
        .clk   (clk),
        .rst   (rst),
        .stat  (stat),
        .ready (ready),
        .phase (phase),
        .kind  (kind)
    );

    stsdec_cmdgen u_cmdgen (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .kind    (kind),
        .strobes (strobes),
        .ale     (ale),
        .den     (den),
        .dir_out (dir_out)
    );

    assign int_ack = strobes.int_ack;
    assign rd_io   = strobes.rd_io;
    assign wr_io   = strobes.wr_io;
    assign rd_mem  = strobes.rd_mem;
    assign wr_mem  = strobes.wr_mem;
    assign any_cmd = |strobes;

    AST_CMD_AFTER_ALE: assert property (@(posedge clk) disable iff (rst)
        $rose(any_cmd) |-> $past(ale)); // R5

    AST_CMD_ENDS: assert property (@(posedge clk) disable iff (rst)
        (any_cmd && stat == ST_IDLE && ready) |=> !any_cmd); // R5

    AST_CMD_STRETCH: assert property (@(posedge clk) disable iff (rst)
        (any_cmd && !ready) |=> $stable(strobes)); // R6

    AST_DEN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        den == any_cmd); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !(ale || any_cmd || den || dir_out)); // R1

endmodule

// File: tb/test_stsdec_top.sv
module test_stsdec_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] stat = 3'b111;
    logic       ready = 1'b1;
    logic ale, int_ack, rd_io, wr_io, rd_mem, wr_mem, den, dir_out;

    int n_checks = 0;
    int n_fail   = 0;

    int         m_ph;
    logic       m_arm;
    logic [2:0] m_kind;

    always #2 clk = ~clk;

    stsdec_top i_stsdec_top (
        .clk(clk), .rst(rst), .stat(stat), .ready(ready),
        .ale(ale), .int_ack(int_ack), .rd_io(rd_io), .wr_io(wr_io),
        .rd_mem(rd_mem), .wr_mem(wr_mem), .den(den), .dir_out(dir_out)
    );

    function automatic logic [7:0] model_out(int ph, logic [2:0] k);
        logic [4:0] c;
        logic       a, d, w;
        c = 5'b0;
        if (ph == 2) begin
            c[4] = (k == 3'b000);
            c[3] = (k == 3'b001);
            c[2] = (k == 3'b010);
            c[1] = (k == 3'b100) || (k == 3'b101);
            c[0] = (k == 3'b110);
        end
        a = (ph == 1) && (k != 3'b011);
        d = |c;
        w = (ph != 0) && (k != 3'b011) && (k == 3'b010 || k == 3'b110);
        return {a, c, d, w};
    endfunction

    task automatic model_step(logic [2:0] s, logic r);
        case (m_ph)
            0: begin
                if (s == 3'b111) m_arm = 1'b1;
                else if (m_arm) begin
                    m_ph = 1; m_kind = s; m_arm = 1'b0;
                end
            end
            1: m_ph = 2;
            default: if (s == 3'b111 && r) m_ph = 0;
        endcase
    endtask

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b (ale,inta,iord,iowr,mrd,mwr,den,dir)",
                     tag, act, exp);
        end
    endtask

    task automatic cyc(string tag, logic [2:0] s, logic r);
        logic [7:0] o;
        stat  = s;
        ready = r;
        @(posedge clk);
        #1;
        model_step(s, r);
        o = {ale, int_ack, rd_io, wr_io, rd_mem, wr_mem, den, dir_out};
        check(tag, o, model_out(m_ph, m_kind));
        if ($countones(o[6:2]) > 1) check("R10", o, model_out(m_ph, m_kind) ^ 8'hFF);
        check("R7", {7'b0, den}, {7'b0, |o[6:2]});
    endtask

    task automatic run_cycle(string tag, logic [2:0] code, int waits);
        cyc(tag, 3'b111, 1'b1);
        cyc(tag, code, 1'b1);
        cyc(tag, code, 1'b1);
        cyc(tag, 3'b111, 1'b0);
        for (int i = 0; i < waits; i++) cyc(tag, 3'b111, 1'b0);
        cyc(tag, 3'b111, 1'b1);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [2:0] s;
        logic       r;
        m_ph = 0; m_arm = 1'b0; m_kind = 3'b111;
        repeat (3) @(posedge clk);
        #1;
        check("R1", {ale, int_ack, rd_io, wr_io, rd_mem, wr_mem, den, dir_out}, 8'b0);
        rst = 1'b0;
        // R1: unarmed after reset, first non-passive ignored
        cyc("R1", 3'b101, 1'b1);
        cyc("R1", 3'b101, 1'b1);
        // R2 / R5: arm then detect a memory read
        run_cycle("R2", 3'b101, 0);
        // R3: every command code, R8 covers the write codes
        run_cycle("R3", 3'b000, 0);
        run_cycle("R3", 3'b001, 1);
        run_cycle("R8", 3'b010, 0);
        run_cycle("R3", 3'b100, 0);
        run_cycle("R8", 3'b110, 2);
        // R4: halt produces nothing
        run_cycle("R4", 3'b011, 1);
        // R6: long stretch with passive status and ready low
        run_cycle("R6", 3'b110, 6);
        // R9: non-passive right after end, then status churn inside a cycle
        cyc("R9", 3'b111, 1'b1);
        cyc("R9", 3'b001, 1'b1);
        cyc("R9", 3'b001, 1'b1);
        cyc("R9", 3'b101, 1'b1);
        cyc("R9", 3'b110, 1'b0);
        cyc("R9", 3'b111, 1'b1);
        cyc("R9", 3'b010, 1'b1);
        cyc("R9", 3'b111, 1'b1);
        cyc("R9", 3'b111, 1'b1);
        // R5 random mix checked against the model
        void'($urandom(32'd4711));
        for (int i = 0; i < 4000; i++) begin
            s = ($urandom % 3 == 0) ? 3'($urandom) : 3'b111;
            r = ($urandom % 4 != 0);
            cyc("R5", s, r);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule